// File: doc/BRIEF.md
# Home-Node Full-Map Directory Controller

This block is the home-node engine of a small shared-memory system with `NPROC` processors. For every memory block it owns, it keeps a directory entry. The entry holds one presence bit per processor and a single dirty bit. It also holds the block's memory word. Processors send read-miss or write-miss requests through a valid/ready port. The controller looks up the entry and issues only the protocol actions that this entry calls for. It sends these actions only to the processors that the presence bits name:

- a recall to the current owner, either keeping a shared copy or with invalidation;
- invalidations to the other sharers, followed by counting their acknowledgements;
- a write-back of recalled data into memory;
- a final data reply to the requester.

Only one request is in flight at any time. `req_ready` stays low from the cycle a request is taken until that request has finished, so requests to the same block can never race. The testbench stands in for the caches and the network: it answers recalls with data and invalidations with acknowledgements.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry has all presence bits clear and the dirty bit clear. Memory word b holds the value b. `req_ready` is 1 and every output strobe (`recall_valid`, `inv_valid`, `reply_valid`, `err_valid`) is 0.
- R2: A read when the dirty bit is clear gets a reply carrying the memory word, with `reply_excl`=0. No recall or invalidation is issued, and the requester's presence bit is set.
- R3: A read when the dirty bit is set sends one recall to the owner with `recall_inv`=0. The owner is the processor whose presence bit is set. The recalled data (`wb_data`, sampled while `wb_valid`=1) is written to memory and returned in the reply. The dirty bit is cleared, and both the owner and the requester remain sharers.
- R4: A write when the dirty bit is clear and other sharers exist issues one `inv_valid` pulse of a single cycle. Its `inv_mask` has bit j set exactly for each sharer j other than the requester. The reply then carries the memory word with `reply_excl`=1.
- R5: The reply to an invalidating write is not given until the number of `ack_valid` cycles received equals the number of bits set in `inv_mask`.
- R6: A write when the dirty bit is set and another processor owns the line sends one recall to that owner with `recall_inv`=1. The recalled data is written to memory and returned in the reply, with `reply_excl`=1.
- R7: After any write, the requester is the only presence bit set and the dirty bit is set. A later request from another processor therefore recalls the line from that requester.
- R8: Any request from the processor that owns a dirty line produces a one-cycle `err_valid` pulse. It gets no reply, no recall and no invalidation, and leaves the entry unchanged.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the reply or error cycle has ended. It returns to 1 in the following cycle.
- R10: Invalidations and recalls never target the requester. A write with no other sharer issues no invalidation.
- R11: At most one of `recall_valid`, `inv_valid`, `reply_valid` and `err_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when both are high |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block number |
| recall_valid | output | 1 | Recall request to owner, held until data returns |
| recall_inv | output | 1 | Recall also invalidates the owner's copy |
| recall_dst | output | $clog2(NPROC) | Owner being recalled |
| recall_blk | output | $clog2(NBLK) | Block being recalled |
| wb_valid | input | 1 | Recalled data present |
| wb_data | input | DW | Recalled data |
| inv_valid | output | 1 | One-cycle invalidation pulse |
| inv_mask | output | NPROC | Processors to invalidate |
| inv_blk | output | $clog2(NBLK) | Block being invalidated |
| ack_valid | input | 1 | One invalidation acknowledgement per cycle high |
| reply_valid | output | 1 | One-cycle data reply |
| reply_excl | output | 1 | Reply grants exclusive (write) ownership |
| reply_dst | output | $clog2(NPROC) | Requester receiving the reply |
| reply_blk | output | $clog2(NBLK) | Block in the reply |
| reply_data | output | DW | Block data |
| err_valid | output | 1 | One-cycle protocol-error pulse |

## Verification
The main function is tried with four kinds of entry state: a clean block with no sharers, a clean block with several sharers, a dirty block owned by another processor, and a dirty block owned by the requester. Reads and writes are each applied to all four. These states separate the four service paths: memory reply, invalidate-and-count, recall with or without invalidation, and error. Acknowledgements arrive with gaps, which shows whether the reply waits for the full count rather than the first acknowledgement. A final random stream of requests over a few blocks checks that presence and dirty state carry correctly from one transaction to the next.

// File: rtl/dir_pkg.sv
// Shared types for the home-node directory controller.
package dir_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RECALL,
        ST_INVAL,
        ST_WAITACK,
        ST_REPLY,
        ST_ERR
    } dir_state_t;
endpackage

// File: rtl/dir_mask_util.sv
// Presence-vector helper: finds the owner of a dirty line (the lowest set
// bit), the set of sharers other than the requester, and how many there are.
// Assumes a dirty entry holds exactly one presence bit.
module dir_mask_util #(
    parameter int NPROC = 4,
    parameter int PW    = 2
) (
    input  logic [NPROC-1:0] pres,
    input  logic [PW-1:0]    src,
    output logic [PW-1:0]    owner,
    output logic [NPROC-1:0] others,
    output logic [PW:0]      others_cnt
);
    // Lowest-numbered set bit is taken as the owner.
    always_comb begin
        owner = '0;
        for (int i = NPROC - 1; i >= 0; i--)
            if (pres[i]) owner = PW'(i);
    end

    // Sharers excluding the requester, and how many of them there are.
    always_comb begin
        others     = pres & ~(NPROC'(1) << src);
        others_cnt = '0;
        for (int i = 0; i < NPROC; i++)
            others_cnt = others_cnt + (PW+1)'(others[i]);
    end
endmodule

// File: rtl/dir_store.sv
// Directory entries and memory words, one of each per block. Reads are
// combinational. There is one write port for the entry and one for the memory
// word, both aimed at the same block. After reset word b holds value b.
module dir_store #(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 8,
    parameter int BW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    blk,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_dirty,
    output logic [DW-1:0]    rd_data,
    input  logic             dir_we,
    input  logic [NPROC-1:0] wr_pres,
    input  logic             wr_dirty,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_wdata
);
    logic [NPROC-1:0] pres_q  [NBLK];
    logic             dirty_q [NBLK];
    logic [DW-1:0]    mem_q   [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_ent
        // Per-block entry and word, updated when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q[b]  <= '0;
                dirty_q[b] <= 1'b0;
                mem_q[b]   <= DW'(b);
            end else begin
                if (dir_we && blk == BW'(b)) begin
                    pres_q[b]  <= wr_pres;
                    dirty_q[b] <= wr_dirty;
                end
                if (mem_we && blk == BW'(b))
                    mem_q[b] <= mem_wdata;
            end
        end
    end

    assign rd_pres  = pres_q[blk];
    assign rd_dirty = dirty_q[blk];
    assign rd_data  = mem_q[blk];
endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node directory controller. It serves one read-miss or write-miss at a
// time. It looks up the entry, then recalls from the owner or invalidates the
// sharers as the entry requires, and then replies and updates the entry.
// Assumes that recall data and acknowledgements come only after a recall or
// invalidation has been issued.
module dir_home_ctrl #(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 8,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [PW-1:0]    req_src,
    input  logic [BW-1:0]    req_blk,
    output logic             recall_valid,
    output logic             recall_inv,
    output logic [PW-1:0]    recall_dst,
    output logic [BW-1:0]    recall_blk,
    input  logic             wb_valid,
    input  logic [DW-1:0]    wb_data,
    output logic             inv_valid,
    output logic [NPROC-1:0] inv_mask,
    output logic [BW-1:0]    inv_blk,
    input  logic             ack_valid,
    output logic             reply_valid,
    output logic             reply_excl,
    output logic [PW-1:0]    reply_dst,
    output logic [BW-1:0]    reply_blk,
    output logic [DW-1:0]    reply_data,
    output logic             err_valid
);
    import dir_pkg::*;

    dir_state_t       state_q, state_d;
    logic [PW-1:0]    src_q, owner_q;
    logic [BW-1:0]    blk_q;
    logic             wr_q;
    logic [PW:0]      ack_cnt_q;

    logic [NPROC-1:0] rd_pres, others, new_pres;
    logic             rd_dirty;
    logic [DW-1:0]    rd_data;
    logic [PW-1:0]    owner;
    logic [PW:0]      others_cnt;
    logic             dir_we, mem_we;

    dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .BW(BW)) u_store (
        .clk(clk), .rst_n(rst_n), .blk(blk_q),
        .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
        .dir_we(dir_we), .wr_pres(new_pres), .wr_dirty(wr_q),
        .mem_we(mem_we), .mem_wdata(wb_data)
    );

    dir_mask_util #(.NPROC(NPROC), .PW(PW)) u_mask (
        .pres(rd_pres), .src(src_q), .owner(owner),
        .others(others), .others_cnt(others_cnt)
    );

    // Next-state selection for the transaction sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOK;
            ST_LOOK: begin
                if (rd_dirty && owner == src_q)        state_d = ST_ERR;
                else if (rd_dirty)                     state_d = ST_RECALL;
                else if (wr_q && others != '0)         state_d = ST_INVAL;
                else                                   state_d = ST_REPLY;
            end
            ST_RECALL:  if (wb_valid) state_d = ST_REPLY;
            ST_INVAL:   state_d = ST_WAITACK;
            ST_WAITACK: if (ack_cnt_q == '0) state_d = ST_REPLY;
            ST_REPLY:   state_d = ST_IDLE;
            ST_ERR:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            blk_q   <= '0;
            wr_q    <= 1'b0;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                src_q <= req_src;
                blk_q <= req_blk;
                wr_q  <= req_write;
            end
            if (state_q == ST_LOOK) owner_q <= owner;
        end
    end

    // Outstanding invalidation acknowledgement counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_cnt_q <= '0;
        else if (state_q == ST_LOOK)
            ack_cnt_q <= others_cnt;
        else if ((state_q == ST_INVAL || state_q == ST_WAITACK) && ack_valid && ack_cnt_q != '0)
            ack_cnt_q <= ack_cnt_q - 1'b1;
    end

    // Entry and memory updates: write-back on recall data, entry on reply.
    always_comb begin
        mem_we   = (state_q == ST_RECALL) && wb_valid;
        dir_we   = (state_q == ST_REPLY);
        new_pres = wr_q ? (NPROC'(1) << src_q) : (rd_pres | (NPROC'(1) << src_q));
    end

    // Output strobes and fields, decoded from the state.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        recall_valid = (state_q == ST_RECALL);
        recall_inv   = wr_q;
        recall_dst   = owner_q;
        recall_blk   = blk_q;
        inv_valid    = (state_q == ST_INVAL);
        inv_mask     = inv_valid ? others : '0;
        inv_blk      = blk_q;
        reply_valid  = (state_q == ST_REPLY);
        reply_excl   = wr_q;
        reply_dst    = src_q;
        reply_blk    = blk_q;
        reply_data   = rd_data;
        err_valid    = (state_q == ST_ERR);
    end
endmodule

// File: rtl/dir_home_chk.sv
// Protocol checker for dir_home_ctrl, attached through bind. It keeps its own
// copy of the requester taken at the port handshake.
module dir_home_chk #(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 8,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [PW-1:0]    req_src,
    input logic             recall_valid,
    input logic [PW-1:0]    recall_dst,
    input logic             inv_valid,
    input logic [NPROC-1:0] inv_mask,
    input logic             reply_valid,
    input logic [PW-1:0]    reply_dst,
    input logic             err_valid
);
    logic [PW-1:0] held_src;

    // Capture the requester when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) held_src <= '0;
        else if (req_valid && req_ready) held_src <= req_src;
    end

    // R11
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({recall_valid, inv_valid, reply_valid, err_valid}));
    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_valid || inv_valid || reply_valid || err_valid) |-> !req_ready);
    // R9
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_valid || err_valid) |=> req_ready);
    // R10
    inv_skips_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (!inv_mask[held_src] && inv_mask != '0));
    // R10
    recall_skips_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_valid |-> recall_dst != held_src);
    // R4
    inv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid);
    // R2
    reply_to_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> reply_dst == held_src);
endmodule

bind dir_home_ctrl dir_home_chk #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .recall_valid(recall_valid), .recall_dst(recall_dst),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .reply_valid(reply_valid),
    .reply_dst(reply_dst), .err_valid(err_valid)
);

// File: tb/sim_dir_home_ctrl.sv
// Bench: a behavioural directory model plays the caches and the network and
// compares the controller's strobes on every clock of each transaction.
module sim_dir_home_ctrl;
    localparam int NPROC = 4;
    localparam int NBLK  = 8;
    localparam int DW    = 8;
    localparam int PW    = $clog2(NPROC);
    localparam int BW    = $clog2(NBLK);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, wb_valid = 0, ack_valid = 0;
    logic [PW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic [DW-1:0] wb_data = '0;
    logic req_ready, recall_valid, recall_inv, inv_valid, reply_valid, reply_excl, err_valid;
    logic [PW-1:0] recall_dst, reply_dst;
    logic [BW-1:0] recall_blk, inv_blk, reply_blk;
    logic [NPROC-1:0] inv_mask;
    logic [DW-1:0] reply_data;

    int errors = 0, checks = 0, seq = 0;
    bit finished = 0;
    int m_pres [NBLK];
    bit m_dirty [NBLK];
    int m_mem [NBLK];
    int m_own [NBLK];

    always #4 clk = ~clk;

    dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_src(req_src), .req_blk(req_blk),
        .recall_valid(recall_valid), .recall_inv(recall_inv), .recall_dst(recall_dst),
        .recall_blk(recall_blk), .wb_valid(wb_valid), .wb_data(wb_data),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_blk(inv_blk),
        .ack_valid(ack_valid), .reply_valid(reply_valid), .reply_excl(reply_excl),
        .reply_dst(reply_dst), .reply_blk(reply_blk), .reply_data(reply_data),
        .err_valid(err_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One transaction against the model; every clock is compared.
    task automatic do_req(input int src, input int blk, input bit wr);
        int pres = m_pres[blk], owner = 0, others, cnt = 0, acks_left = 0, exp_data;
        bit exp_err, exp_recall, exp_inv, seen_recall = 0, seen_inv = 0, done = 0, gap = 1;
        for (int i = NPROC - 1; i >= 0; i--) if (pres[i]) owner = i;
        exp_err    = m_dirty[blk] && owner == src;
        exp_recall = m_dirty[blk] && !exp_err;
        others     = pres & ~(1 << src);
        exp_inv    = !m_dirty[blk] && wr && others != 0;
        for (int i = 0; i < NPROC; i++) cnt += (others >> i) & 1;
        exp_data   = exp_recall ? m_own[blk] : m_mem[blk];

        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready idle", int'(req_ready), 1);
        req_valid = 1; req_write = wr; req_src = PW'(src); req_blk = BW'(blk);
        @(negedge clk);
        req_valid = 0;
        check(req_ready == 1'b0, "R9 busy", int'(req_ready), 0);
        for (int c = 0; c < 40 && !done; c++) begin
            @(negedge clk);
            wb_valid = 0; ack_valid = 0;
            check($countones({recall_valid, inv_valid, reply_valid, err_valid}) <= 1,
                  "R11 exclusive", $countones({recall_valid, inv_valid, reply_valid, err_valid}), 1);
            check(req_ready == 1'b0, "R9 busy", int'(req_ready), 0);
            if (err_valid) begin
                check(exp_err, "R8 error expected", 1, int'(exp_err));
                done = 1;
            end
            if (recall_valid) begin
                check(exp_recall && !seen_recall, "R3/R6 recall expected", 1, int'(exp_recall));
                check(int'(recall_dst) == owner && int'(recall_blk) == blk,
                      "R10 recall target", int'(recall_dst), owner);
                check(recall_inv == wr, "R3/R6 recall_inv", int'(recall_inv), int'(wr));
                seen_recall = 1;
                wb_valid = 1; wb_data = DW'(m_own[blk]);
            end
            if (inv_valid) begin
                check(exp_inv && !seen_inv, "R4 inv expected", 1, int'(exp_inv));
                check(int'(inv_mask) == others && int'(inv_blk) == blk, "R4 R10 inv mask",
                      int'(inv_mask), others);
                seen_inv = 1; acks_left = cnt;
            end
            if (reply_valid) begin
                check(!exp_err, "R8 no reply on error", 1, 0);
                check(int'(reply_dst) == src && int'(reply_blk) == blk, "R2 reply target",
                      int'(reply_dst), src);
                check(int'(reply_data) == exp_data, "R2/R3/R6 reply data", int'(reply_data), exp_data);
                check(reply_excl == wr, "R4 reply_excl", int'(reply_excl), int'(wr));
                check(acks_left == 0, "R5 reply before all acks", acks_left, 0);
                check(seen_recall == exp_recall && seen_inv == exp_inv, "R10 actions before reply",
                      int'({seen_recall, seen_inv}), int'({exp_recall, exp_inv}));
                done = 1;
            end
            if (!done && seen_inv && acks_left > 0) begin
                if (gap) begin ack_valid = 1; acks_left--; end
                gap = !gap;
            end
        end
        check(done, "R9 transaction completes", int'(done), 1);
        @(negedge clk);
        wb_valid = 0; ack_valid = 0;
        check(req_ready == 1'b1 && !recall_valid && !inv_valid && !reply_valid && !err_valid,
              "R9 idle after", int'(req_ready), 1);
        if (!exp_err) begin
            if (exp_recall) m_mem[blk] = m_own[blk];
            if (wr) begin
                m_pres[blk] = 1 << src; m_dirty[blk] = 1;
                seq++; m_own[blk] = (8'h80 + seq * 7) & 8'hFF;
            end else begin
                m_pres[blk] = m_pres[blk] | (1 << src); m_dirty[blk] = 0;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NBLK; b++) begin
            m_pres[b] = 0; m_dirty[b] = 0; m_mem[b] = b; m_own[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !recall_valid && !inv_valid && !reply_valid && !err_valid,
              "R1 reset outputs", int'(req_ready), 1);
        do_req(0, 0, 0);   // R1 R2 clean read returns reset word
        do_req(1, 0, 0);
        do_req(2, 0, 0);
        do_req(1, 0, 1);   // R4 R5 invalidate p0 and p2
        do_req(3, 0, 0);   // R3 recall from p1
        do_req(2, 0, 0);   // R3 now clean, served from memory
        do_req(2, 1, 1);   // R10 write with no sharers
        do_req(0, 1, 1);   // R6 recall with invalidate
        do_req(0, 1, 1);   // R8 owner writes again
        do_req(0, 1, 0);   // R8 owner reads
        do_req(3, 1, 0);   // R7 R8 entry unchanged, recall to p0
        do_req(3, 5, 0);   // R1 word 5 holds 5
        for (int n = 0; n < 80; n++)
            do_req(int'($urandom_range(NPROC - 1)), int'($urandom_range(3)), 1'($urandom_range(1)));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule